// File: doc/BRIEF.md
# Multi-Channel Temperature Threshold Interrupt Controller

This block watches up to sixteen temperature channels. Digitized samples arrive on a strobe that carries a channel number and a signed value in tenths of a degree. For each channel the block keeps the latest sample and a valid flag, and holds three programmable limits: lower, upper and critical. Each sample is compared against its channel's limits. The result sets three status bits, which are re-evaluated on every later sample, so a status bit stays asserted only while the violation lasts.

Two level-sensitive interrupt lines are built from the status bits. The first, the limit line, combines upper and lower events. The second carries critical events only. Each event class has a mask bit and a clear bit on every channel. Software acknowledges an event by raising the clear bit and then dropping it. A three-bit global enable gates the upper, lower and critical paths. A flat register port gives read and write access to all of this state. A read returns its data one cycle after the address is presented.

Top module: `thermal_irq_ctrl`

## Requirements
- R1: After reset, all limits, status bits, clear bits and enables are 0, all mask bits are 1, both interrupt lines are low, and each channel's sample word reads valid with value 0.
- R2: The register address is {sel[2:0], channel}, and a read returns on reg_rdata one cycle after the address is presented. The sel codes are: 0 sample word (bit 15 valid, bits 11:0 value), 1 lower limit, 2 upper limit, 3 critical limit, 4 control, 5 status, 6 global enable. Limits read back sign-extended to 16 bits.
- R3: A sample greater than or equal to the channel's upper limit (signed) sets status bit 0.
- R4: A sample less than or equal to the channel's lower limit (signed) sets status bit 1.
- R5: A sample greater than or equal to the channel's critical limit (signed) sets status bit 2.
- R6: Status bits change only on a new sample for that channel or while a clear bit is high. A sample back inside the limits drops the status bit, and the interrupt line then deasserts by itself.
- R7: While a control clear bit is high (bit 4 upper, bit 5 lower, bit 6 critical), the matching status bit is forced to 0, including across samples. After the clear bit drops, the status bit stays 0 until the next sample re-evaluates it.
- R8: A control mask bit (bit 0 upper, bit 1 lower, bit 2 critical) at 1 keeps that channel's event off its interrupt line. Writing 0 lets the event through.
- R9: The limit line goes high one cycle after any channel has upper status unmasked with enable bit 0 set, or lower status unmasked with enable bit 1 set.
- R10: The critical line goes high one cycle after any channel has critical status unmasked with enable bit 2 set. It is independent of the limit line.
- R11: After each sample, the channel's valid flag reads 0 for exactly 6 cycles, and the new value is then readable with valid set to 1.
- R12: A sample or register write for one channel leaves every other channel's sample word, limits and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| smp_ch | input | CHW | Channel of the sample |
| smp_val | input | TW | Signed sample, tenths of a degree |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3+CHW | Register address {sel, channel} |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data |
| irq_limit | output | 1 | Level interrupt for upper and lower events |
| irq_crit | output | 1 | Level interrupt for critical events |

## Verification
The bench builds the block with four channels, 12-bit samples, a 16-bit data word and a valid hold time of six cycles. With four channels, the bench can observe an untouched neighbour channel alongside the active one. With 12-bit samples, negative limits such as -40.0 C exercise the signed compare and the sign extension on readback. With a hold of six cycles, the bench can step through the valid-low window cycle by cycle.

// File: rtl/tic_pkg.sv
package tic_pkg;
  typedef enum logic [2:0] {
    SEL_TEMP = 3'd0,
    SEL_LO   = 3'd1,
    SEL_UP   = 3'd2,
    SEL_CRIT = 3'd3,
    SEL_CTL  = 3'd4,
    SEL_STAT = 3'd5,
    SEL_EN   = 3'd6,
    SEL_NONE = 3'd7
  } sel_e;

  // event bit positions shared by mask, clear, status and enable fields
  localparam int EV_UP   = 0;
  localparam int EV_LO   = 1;
  localparam int EV_CRIT = 2;
  localparam int CLR_OFS = 4;
endpackage

// File: rtl/tic_channel.sv
module tic_channel #(
  parameter int TW   = 12,
  parameter int HOLD = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [TW-1:0] smp_val,
  input  logic          wr_lo,
  input  logic          wr_up,
  input  logic          wr_cr,
  input  logic          wr_ctl,
  input  logic [TW-1:0] wval,
  input  logic [5:0]    wctl,
  output logic [TW-1:0] lo_th,
  output logic [TW-1:0] up_th,
  output logic [TW-1:0] cr_th,
  output logic [2:0]    mask,
  output logic [2:0]    clr,
  output logic [2:0]    stat,
  output logic [TW-1:0] temp,
  output logic          valid
);
  import tic_pkg::*;
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] hold_cnt;
  logic [2:0]    cmp;

  always_comb begin
    cmp[EV_UP]   = $signed(smp_val) >= $signed(up_th);
    cmp[EV_LO]   = $signed(smp_val) <= $signed(lo_th);
    cmp[EV_CRIT] = $signed(smp_val) >= $signed(cr_th);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_th <= '0;
      up_th <= '0;
      cr_th <= '0;
      mask  <= 3'b111;
      clr   <= 3'b000;
    end else begin
      if (wr_lo)  lo_th <= wval;
      if (wr_up)  up_th <= wval;
      if (wr_cr)  cr_th <= wval;
      if (wr_ctl) {clr, mask} <= wctl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
    end else begin
      for (int b = 0; b < 3; b++) begin
        if (clr[b])   stat[b] <= 1'b0;
        else if (hit) stat[b] <= cmp[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      temp     <= '0;
      hold_cnt <= '0;
    end else if (hit) begin
      temp     <= smp_val;
      hold_cnt <= CW'(HOLD);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign valid = (hold_cnt == '0);

  assert_valid_drop_R11: assert property (@(posedge clk) disable iff (rst)
    hit |=> !valid);
  assert_clear_forces_R7: assert property (@(posedge clk) disable iff (rst)
    clr[EV_UP] |=> !stat[EV_UP]);
  assert_status_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!hit && !clr[EV_LO]) |=> $stable(stat[EV_LO]));
endmodule

// File: rtl/tic_irq_merge.sv
module tic_irq_merge #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] st_up,
  input  logic [NUM_CH-1:0] st_lo,
  input  logic [NUM_CH-1:0] st_cr,
  input  logic [NUM_CH-1:0] m_up,
  input  logic [NUM_CH-1:0] m_lo,
  input  logic [NUM_CH-1:0] m_cr,
  input  logic [2:0]        en,
  output logic              irq_limit,
  output logic              irq_crit
);
  import tic_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_limit <= 1'b0;
      irq_crit  <= 1'b0;
    end else begin
      irq_limit <= (en[EV_UP] && |(st_up & ~m_up)) ||
                   (en[EV_LO] && |(st_lo & ~m_lo));
      irq_crit  <= en[EV_CRIT] && |(st_cr & ~m_cr);
    end
  end

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (en == 3'b000) |=> (!irq_limit && !irq_crit));
  assert_all_masked_R8: assert property (@(posedge clk) disable iff (rst)
    ((&m_up) && (&m_lo)) |=> !irq_limit);
  assert_crit_masked_R10: assert property (@(posedge clk) disable iff (rst)
    (&m_cr) |=> !irq_crit);
endmodule

// File: rtl/thermal_irq_ctrl.sv
module thermal_irq_ctrl #(
  parameter int NUM_CH = 16,
  parameter int TW     = 12,
  parameter int DW     = 16,
  parameter int HOLD   = 6,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW    = 3 + CHW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld,
  input  logic [CHW-1:0] smp_ch,
  input  logic [TW-1:0] smp_val,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_limit,
  output logic          irq_crit
);
  import tic_pkg::*;
  localparam int PAD = DW - 1 - TW;

  sel_e           a_sel;
  logic [CHW-1:0] a_ch;
  logic [2:0]     en;
  logic [NUM_CH-1:0] st_up, st_lo, st_cr, m_up, m_lo, m_cr, vld;
  logic [TW-1:0]  lo_th [NUM_CH];
  logic [TW-1:0]  up_th [NUM_CH];
  logic [TW-1:0]  cr_th [NUM_CH];
  logic [TW-1:0]  temp  [NUM_CH];
  logic [2:0]     mask  [NUM_CH];
  logic [2:0]     clr   [NUM_CH];
  logic [2:0]     stat  [NUM_CH];
  logic [DW-1:0]  rd_mux;
  logic           unused_wdata;

  assign a_sel = sel_e'(reg_addr[AW-1:CHW]);
  assign a_ch  = reg_addr[CHW-1:0];
  assign unused_wdata = ^reg_wdata[DW-1:TW];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ch_sel;
    assign ch_sel = (a_ch == CHW'(i));
    tic_channel #(.TW(TW), .HOLD(HOLD)) u_ch (
      .clk(clk), .rst(rst),
      .hit(smp_vld && (smp_ch == CHW'(i))),
      .smp_val(smp_val),
      .wr_lo(reg_we && ch_sel && a_sel == SEL_LO),
      .wr_up(reg_we && ch_sel && a_sel == SEL_UP),
      .wr_cr(reg_we && ch_sel && a_sel == SEL_CRIT),
      .wr_ctl(reg_we && ch_sel && a_sel == SEL_CTL),
      .wval(reg_wdata[TW-1:0]),
      .wctl({reg_wdata[CLR_OFS+2:CLR_OFS], reg_wdata[2:0]}),
      .lo_th(lo_th[i]), .up_th(up_th[i]), .cr_th(cr_th[i]),
      .mask(mask[i]), .clr(clr[i]), .stat(stat[i]),
      .temp(temp[i]), .valid(vld[i])
    );
    assign st_up[i] = stat[i][EV_UP];
    assign st_lo[i] = stat[i][EV_LO];
    assign st_cr[i] = stat[i][EV_CRIT];
    assign m_up[i]  = mask[i][EV_UP];
    assign m_lo[i]  = mask[i][EV_LO];
    assign m_cr[i]  = mask[i][EV_CRIT];
  end

  always_ff @(posedge clk) begin
    if (rst)                           en <= 3'b000;
    else if (reg_we && a_sel == SEL_EN) en <= reg_wdata[2:0];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (a_ch == CHW'(i)) begin
        case (a_sel)
          SEL_TEMP: rd_mux = {vld[i], {PAD{1'b0}}, temp[i]};
          SEL_LO:   rd_mux = {{(DW-TW){lo_th[i][TW-1]}}, lo_th[i]};
          SEL_UP:   rd_mux = {{(DW-TW){up_th[i][TW-1]}}, up_th[i]};
          SEL_CRIT: rd_mux = {{(DW-TW){cr_th[i][TW-1]}}, cr_th[i]};
          SEL_CTL:  rd_mux = DW'({clr[i], 1'b0, mask[i]});
          SEL_STAT: rd_mux = DW'(stat[i]);
          default:  rd_mux = '0;
        endcase
      end
    end
    if (a_sel == SEL_EN) rd_mux = DW'(en);
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  tic_irq_merge #(.NUM_CH(NUM_CH)) u_merge (
    .clk(clk), .rst(rst),
    .st_up(st_up), .st_lo(st_lo), .st_cr(st_cr),
    .m_up(m_up), .m_lo(m_lo), .m_cr(m_cr),
    .en(en), .irq_limit(irq_limit), .irq_crit(irq_crit)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_limit && !irq_crit));
endmodule

// File: tb/thermal_irq_ctrl_test.sv
module thermal_irq_ctrl_test;
  localparam int NUM_CH = 4;
  localparam int TW = 12;
  localparam int DW = 16;
  localparam int CHW = 2;
  localparam int AW = 3 + CHW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic [CHW-1:0] smp_ch = '0;
  logic [TW-1:0] smp_val = '0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq_limit, irq_crit;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  thermal_irq_ctrl #(.NUM_CH(NUM_CH), .TW(TW), .DW(DW), .HOLD(6)) uut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_ch(smp_ch), .smp_val(smp_val),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_limit(irq_limit), .irq_crit(irq_crit)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] ad(input int sel, input int ch);
    return {3'(sel), CHW'(ch)};
  endfunction

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic smp(input int ch, input int val);
    smp_ch = CHW'(ch); smp_val = TW'(val); smp_vld = 1'b1;
    @(posedge clk); #1;
    smp_vld = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 irq_limit", 16'(irq_limit), 16'h0);
    check("R1 irq_crit", 16'(irq_crit), 16'h0);
    rd(ad(0, 0), d); check("R1 sample word", d, 16'h8000);
    rd(ad(1, 0), d); check("R1 lower limit", d, 16'h0000);
    rd(ad(3, 0), d); check("R1 crit limit", d, 16'h0000);
    rd(ad(4, 0), d); check("R1 control masks", d, 16'h0007);
    rd(ad(5, 0), d); check("R1 status", d, 16'h0000);
    rd(ad(6, 0), d); check("R1 enable", d, 16'h0000);
  endtask

  task automatic t_regs();
    logic [DW-1:0] d;
    wr(ad(1, 1), 16'(-400));
    wr(ad(2, 1), 16'd850);
    wr(ad(3, 1), 16'd1100);
    rd(ad(1, 1), d); check("R2 lower sign-extended", d, 16'hFE70);
    rd(ad(2, 1), d); check("R2 upper readback", d, 16'd850);
    rd(ad(3, 1), d); check("R2 crit readback", d, 16'd1100);
    rd(ad(1, 0), d); check("R12 ch0 lower untouched", d, 16'h0000);
  endtask

  task automatic t_upper();
    logic [DW-1:0] d;
    wr(ad(4, 1), 16'h0006);
    wr(ad(6, 0), 16'h0003);
    smp(1, 850);
    tick(); check("R9 limit irq on upper", 16'(irq_limit), 16'h1);
    rd(ad(5, 1), d); check("R3 upper status at equal", d, 16'h0001);
    smp(1, 849);
    rd(ad(5, 1), d); check("R6 status drops in range", d, 16'h0000);
    check("R6 irq deasserts by itself", 16'(irq_limit), 16'h0);
  endtask

  task automatic t_lower();
    logic [DW-1:0] d;
    wr(ad(4, 1), 16'h0005);
    smp(1, -400);
    rd(ad(5, 1), d); check("R4 lower status at equal", d, 16'h0002);
    check("R9 limit irq on lower", 16'(irq_limit), 16'h1);
    smp(1, -500);
    rd(ad(5, 1), d); check("R4 lower status below", d, 16'h0002);
  endtask

  task automatic t_mask();
    wr(ad(4, 1), 16'h0007);
    tick(); check("R8 masked lower blocked", 16'(irq_limit), 16'h0);
    wr(ad(4, 1), 16'h0005);
    tick(); check("R8 unmasked again", 16'(irq_limit), 16'h1);
    wr(ad(6, 0), 16'h0001);
    tick(); check("R9 lower path disabled", 16'(irq_limit), 16'h0);
  endtask

  task automatic t_crit();
    logic [DW-1:0] d;
    wr(ad(4, 1), 16'h0000);
    wr(ad(6, 0), 16'h0007);
    smp(1, 1200);
    rd(ad(5, 1), d); check("R5 crit and upper status", d, 16'h0005);
    check("R10 crit irq", 16'(irq_crit), 16'h1);
    check("R9 limit irq", 16'(irq_limit), 16'h1);
    wr(ad(6, 0), 16'h0003);
    tick(); check("R10 crit path disabled", 16'(irq_crit), 16'h0);
    check("R10 limit line independent", 16'(irq_limit), 16'h1);
  endtask

  task automatic t_clear();
    logic [DW-1:0] d;
    wr(ad(4, 1), 16'h0010);
    tick();
    rd(ad(5, 1), d); check("R7 clear forces upper 0", d, 16'h0004);
    check("R7 limit irq after clear", 16'(irq_limit), 16'h0);
    smp(1, 1200);
    rd(ad(5, 1), d); check("R7 held clear across sample", d, 16'h0004);
    wr(ad(4, 1), 16'h0000);
    tick();
    rd(ad(5, 1), d); check("R7 stays 0 until sample", d, 16'h0004);
    smp(1, 1200);
    rd(ad(5, 1), d); check("R7 re-evaluated on sample", d, 16'h0005);
  endtask

  task automatic t_valid();
    logic [DW-1:0] d;
    smp(2, 333);
    for (int k = 0; k < 6; k++) begin
      rd(ad(0, 2), d); check("R11 valid low window", 16'(d[15]), 16'h0);
    end
    rd(ad(0, 2), d); check("R11 valid with value", d, 16'h814D);
    rd(ad(0, 3), d); check("R12 ch3 sample untouched", d, 16'h8000);
    rd(ad(5, 3), d); check("R12 ch3 status untouched", d, 16'h0000);
    rd(ad(2, 1), d); check("R12 ch1 upper untouched", d, 16'd850);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_regs();
    t_upper();
    t_lower();
    t_mask();
    t_crit();
    t_clear();
    t_valid();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule